// File: doc/BRIEF.md
# Alternating Injected Trigger Sequencer

This block takes one external trigger for injected channel groups and hands each trigger to one of two conversion engines in turn. The first trigger launches the whole injected group of engine A. The next one launches engine B's group. After B's group has finished, the turn returns to engine A. Each engine is seen only through a one-cycle group-start pulse that the block sends and a one-cycle group-done strobe that the engine returns.

For each engine the block keeps a sticky end-of-group flag. The flag drives an interrupt line when that engine's interrupt enable is set. A trigger that arrives while the engine whose turn it is is still converting is discarded, and a sticky dropped-trigger flag records it. Clearing the mode-enable input abandons any group in flight and points the turn back at engine A.

The sequencer is one state machine with four states. `ST_WAIT_A` waits for a trigger for A. `ST_RUN_A` waits for A's group to finish. `ST_WAIT_B` and `ST_RUN_B` do the same for B. It has these transitions:
- `WAIT_A→RUN_A`: a trigger edge arrives; a start pulse is sent to A.
- `RUN_A→WAIT_B`: A's done strobe arrives.
- `WAIT_B→RUN_B`: a trigger edge arrives; a start pulse is sent to B.
- `RUN_B→WAIT_A`: B's done strobe arrives.
- any state `→WAIT_A`: mode-enable is low.

Top module: `alt_inj_trig_seq`

## Requirements
- R1: After reset, `grp_start`, `done_flag`, `irq` and `drop_flag` are all zero, and the first trigger goes to engine A (bit 0).
- R2: `trig_in` passes through a SYNC_STAGES-flop synchronizer, and only its rising edge counts as a trigger. Take the clock edge that first samples `trig_in` high as edge 1. The start pulse is then visible after clock edge SYNC_STAGES+1. A trigger held high produces exactly one start.
- R3: A trigger in `ST_WAIT_A` pulses `grp_start[0]` for exactly one cycle. `grp_start[1]` stays low.
- R4: After engine A's group is done, the next trigger pulses `grp_start[1]` for one cycle.
- R5: After engine B's group is done, the next trigger goes back to engine A (`grp_start[0]`).
- R6: A trigger that arrives while the selected engine is converting starts nothing and sets `drop_flag`. `drop_flag` stays set until `drop_clr` is pulsed.
- R7: `done_flag[i]` sets on `grp_done[i]` only while engine i's group is running. A done strobe from an engine that is not running has no effect.
- R8: Each `done_flag` bit stays set until its `done_clr` bit is written as 1. If a set and a clear happen in the same cycle, the flag ends up set.
- R9: `irq[i]` is high exactly when `done_flag[i]` and `irq_en[i]` are both high.
- R10: While `mode_en` is low, triggers start nothing and are not counted as dropped, and the turn returns to engine A. A done strobe for a group abandoned this way does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Enables alternating trigger routing |
| trig_in | input | 1 | Asynchronous external injected trigger |
| grp_done | input | 2 | Group-done strobe per engine (bit 0 = A, bit 1 = B) |
| irq_en | input | 2 | Interrupt enable per engine |
| done_clr | input | 2 | Write-one-to-clear for the done flags |
| drop_clr | input | 1 | Write-one-to-clear for the dropped-trigger flag |
| grp_start | output | 2 | One-cycle group-start pulse per engine |
| done_flag | output | 2 | Sticky end-of-group flag per engine |
| irq | output | 2 | End-of-group interrupt per engine |
| drop_flag | output | 1 | Sticky dropped-trigger flag |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2. With the deeper chain, an off-by-one in the synchronizer depth or in the edge register shows up as a start pulse one cycle early or late against the model, and the directed latency check catches it. With three stages there are also more cycles in which a trigger is in flight while the FSM changes turn, so mode toggles and done strobes can be placed inside that window.

// File: rtl/alt_trig_pkg.sv
package alt_trig_pkg;

    localparam int ENG_A   = 0;
    localparam int ENG_B   = 1;
    localparam int NUM_ENG = 2;

    typedef enum logic [1:0] {
        ST_WAIT_A = 2'd0,
        ST_RUN_A  = 2'd1,
        ST_WAIT_B = 2'd2,
        ST_RUN_B  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise_pulse = chain_q[LAST] & ~prev_q;

    // R2: a level held high yields a single-cycle edge pulse
    a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/alt_seq_fsm.sv
module alt_seq_fsm
    import alt_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en,
    input  logic               trig_edge,
    input  logic [NUM_ENG-1:0] grp_done,
    output logic [NUM_ENG-1:0] start_q,
    output logic [NUM_ENG-1:0] grp_fin,
    output logic               drop_evt
);

    seq_state_e state_q, state_d;
    logic [NUM_ENG-1:0] launch;

    // next-state logic and event decode
    always_comb begin
        state_d  = state_q;
        launch   = '0;
        grp_fin  = '0;
        drop_evt = 1'b0;
        if (!mode_en) begin
            state_d = ST_WAIT_A;
        end else begin
            unique case (state_q)
                ST_WAIT_A: begin
                    if (trig_edge) begin
                        launch[ENG_A] = 1'b1;
                        state_d       = ST_RUN_A;
                    end
                end
                ST_RUN_A: begin
                    if (trig_edge) drop_evt = 1'b1;
                    if (grp_done[ENG_A]) begin
                        grp_fin[ENG_A] = 1'b1;
                        state_d        = ST_WAIT_B;
                    end
                end
                ST_WAIT_B: begin
                    if (trig_edge) begin
                        launch[ENG_B] = 1'b1;
                        state_d       = ST_RUN_B;
                    end
                end
                ST_RUN_B: begin
                    if (trig_edge) drop_evt = 1'b1;
                    if (grp_done[ENG_B]) begin
                        grp_fin[ENG_B] = 1'b1;
                        state_d        = ST_WAIT_A;
                    end
                end
                default: state_d = ST_WAIT_A;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_A;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= launch;
    end

    a_r3_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_q));

    a_r3_start_a_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start_q[ENG_A] |-> (state_q == ST_RUN_A || !$past(mode_en) || state_q == ST_WAIT_B));

    a_r4_fin_a_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_fin[ENG_A] && mode_en) |=> (state_q == ST_WAIT_B || state_q == ST_WAIT_A));

    a_r5_fin_b_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        grp_fin[ENG_B] |=> (state_q == ST_WAIT_A));

    a_r10_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (start_q == '0 && state_q == ST_WAIT_A));

endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        flag_q[i] <= 1'b0;
                else if (set_i[i]) flag_q[i] <= 1'b1;
                else if (clr_i[i]) flag_q[i] <= 1'b0;
            end

            // R8: a set always lands, even against a clear
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flag_q[i]);

            a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !flag_q[i]);

            a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
        end
    endgenerate

endmodule

// File: rtl/alt_inj_trig_seq.sv
module alt_inj_trig_seq
    import alt_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  logic       trig_in,
    input  logic [1:0] grp_done,
    input  logic [1:0] irq_en,
    input  logic [1:0] done_clr,
    input  logic       drop_clr,
    output logic [1:0] grp_start,
    output logic [1:0] done_flag,
    output logic [1:0] irq,
    output logic       drop_flag
);

    localparam int FLAGS = NUM_ENG + 1;

    logic               trig_edge;
    logic [NUM_ENG-1:0] grp_fin;
    logic               drop_evt;
    logic [FLAGS-1:0]   flags;

    trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (trig_in),
        .rise_pulse (trig_edge)
    );

    alt_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .trig_edge (trig_edge),
        .grp_done  (grp_done),
        .start_q   (grp_start),
        .grp_fin   (grp_fin),
        .drop_evt  (drop_evt)
    );

    sticky_flag_bank #(.WIDTH(FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({drop_evt, grp_fin}),
        .clr_i  ({drop_clr, done_clr}),
        .flag_q (flags)
    );

    assign done_flag = flags[NUM_ENG-1:0];
    assign drop_flag = flags[NUM_ENG];
    assign irq       = done_flag & irq_en;

    // R7: a done strobe with no running group never raises a flag
    a_r7_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_flag[ENG_B] && !done_clr[ENG_B] && !grp_fin[ENG_B]) |=> !done_flag[ENG_B]);

    // R6: a dropped trigger never produces a start
    a_r6_drop_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> (grp_start == '0));

    // R9: interrupt only with its flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq & ~done_flag) == 0);

endmodule

// File: tb/alt_inj_trig_seq_tb_top.sv
module alt_inj_trig_seq_tb_top;

    localparam int NS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0;
    logic       trig_in = 1'b0;
    logic [1:0] grp_done = '0;
    logic [1:0] irq_en = '0;
    logic [1:0] done_clr = '0;
    logic       drop_clr = 1'b0;
    logic [1:0] grp_start;
    logic [1:0] done_flag;
    logic [1:0] irq;
    logic       drop_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    alt_inj_trig_seq #(.SYNC_STAGES(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .trig_in(trig_in),
        .grp_done(grp_done), .irq_en(irq_en), .done_clr(done_clr),
        .drop_clr(drop_clr), .grp_start(grp_start), .done_flag(done_flag),
        .irq(irq), .drop_flag(drop_flag)
    );

    // ---------------- behavioural reference model ----------------
    int   m_hist[$];
    int   m_prev;
    int   m_turn;     // 0 = A next, 1 = A busy, 2 = B next, 3 = B busy
    bit   m_start[2];
    bit   m_flag[2];
    bit   m_drop;

    task automatic model_reset();
        m_hist.delete();
        for (int i = 0; i < NS; i++) m_hist.push_back(0);
        m_prev = 0; m_turn = 0;
        m_start[0] = 0; m_start[1] = 0;
        m_flag[0] = 0; m_flag[1] = 0; m_drop = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit edge_seen, fin0, fin1, dr;
            int oldest;
            oldest = m_hist[NS-1];
            edge_seen = (oldest == 1) && (m_prev == 0);
            fin0 = 0; fin1 = 0; dr = 0;
            m_start[0] = 0; m_start[1] = 0;
            if (!mode_en) m_turn = 0;
            else if (m_turn == 0) begin
                if (edge_seen) begin m_start[0] = 1; m_turn = 1; end
            end else if (m_turn == 1) begin
                if (edge_seen) dr = 1;
                if (grp_done[0]) begin fin0 = 1; m_turn = 2; end
            end else if (m_turn == 2) begin
                if (edge_seen) begin m_start[1] = 1; m_turn = 3; end
            end else begin
                if (edge_seen) dr = 1;
                if (grp_done[1]) begin fin1 = 1; m_turn = 0; end
            end
            if (fin0) m_flag[0] = 1; else if (done_clr[0]) m_flag[0] = 0;
            if (fin1) m_flag[1] = 1; else if (done_clr[1]) m_flag[1] = 0;
            if (dr) m_drop = 1; else if (drop_clr) m_drop = 0;
            m_prev = oldest;
            void'(m_hist.pop_back());
            m_hist.push_front(int'(trig_in));
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] es, ef, ei;
            es = {m_start[1], m_start[0]};
            ef = {m_flag[1], m_flag[0]};
            ei = ef & irq_en;
            check(grp_start == es, "R3/R4/R5 grp_start", grp_start, es);
            check(done_flag == ef, "R7/R8 done_flag", done_flag, ef);
            check(irq == ei, "R9 irq", irq, ei);
            check(drop_flag == m_drop, "R6 drop_flag", drop_flag, m_drop);
            if (grp_start[0]) cnt_a++;
            if (grp_start[1]) cnt_b++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic fire();
        trig_in = 1'b1; tick(NS + 3);
        trig_in = 1'b0; tick(NS + 3);
    endtask

    task automatic done_pulse(input int e);
        grp_done[e] = 1'b1; tick(1); grp_done[e] = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int lat, a0, b0;
        tick(3);
        // R1 reset state
        check({grp_start, done_flag, irq, drop_flag} == 7'd0, "R1 reset outputs",
              {grp_start, done_flag, irq, drop_flag}, 0);
        rst_n = 1'b1; tick(2);
        mode_en = 1'b1; irq_en = 2'b11; tick(2);

        // R2 latency and R3 first start on engine A
        trig_in = 1'b1;
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); lat++;
            if (grp_start[0]) break;
        end
        check(lat == NS + 2, "R2 start latency", lat, NS + 2);
        check(grp_start == 2'b01, "R3 first trigger to A", grp_start, 2'b01);
        tick(10);
        check(cnt_a == 1, "R2 held level gives one start", cnt_a, 1);
        trig_in = 1'b0; tick(NS + 3);

        // R6 trigger while A busy is dropped
        fire();
        check(cnt_a == 1 && cnt_b == 0, "R6 busy trigger starts nothing", cnt_a + cnt_b, 1);
        check(drop_flag == 1'b1, "R6 drop flag set", drop_flag, 1);
        drop_clr = 1'b1; tick(1); drop_clr = 1'b0; tick(1);
        check(drop_flag == 1'b0, "R6 drop flag cleared", drop_flag, 0);

        // R7 idle engine done ignored
        done_pulse(1);
        check(done_flag == 2'b00, "R7 idle done ignored", done_flag, 0);
        done_pulse(0);
        check(done_flag == 2'b01, "R7 A done flag", done_flag, 2'b01);
        check(irq == 2'b01, "R9 irq A", irq, 2'b01);

        // R4 next trigger goes to B
        fire();
        check(cnt_b == 1 && cnt_a == 1, "R4 second trigger to B", cnt_b, 1);
        done_pulse(1);
        check(done_flag == 2'b11, "R7 B done flag", done_flag, 2'b11);

        // R9 enable masks
        irq_en = 2'b10; tick(1);
        check(irq == 2'b10, "R9 irq masked", irq, 2'b10);

        // R8 clear and set-beats-clear
        done_clr = 2'b01; tick(1); done_clr = 2'b00; tick(1);
        check(done_flag == 2'b10, "R8 w1c clears A only", done_flag, 2'b10);

        // R5 wrap back to A
        fire();
        check(cnt_a == 2 && cnt_b == 1, "R5 wrap to A", cnt_a, 2);
        grp_done[0] = 1'b1; done_clr[0] = 1'b1; tick(1);
        grp_done[0] = 1'b0; done_clr[0] = 1'b0; tick(1);
        check(done_flag[0] == 1'b1, "R8 set beats clear", done_flag[0], 1);

        // R10 abandon B group with mode off
        fire();
        check(cnt_b == 2, "R10 pre B start", cnt_b, 2);
        done_clr = 2'b11; tick(1); done_clr = 2'b00;
        mode_en = 1'b0; tick(2);
        done_pulse(1);
        check(done_flag == 2'b00, "R10 abandoned done ignored", done_flag, 0);
        a0 = cnt_a; b0 = cnt_b;
        fire();
        check(cnt_a == a0 && cnt_b == b0 && drop_flag == 1'b0,
              "R10 trigger ignored while off", cnt_a + cnt_b, a0 + b0);
        mode_en = 1'b1; tick(2);
        fire();
        check(cnt_a == a0 + 1 && cnt_b == b0, "R10 turn reset to A", cnt_a, a0 + 1);
        done_pulse(0);
        tick(5);
        finish_run();
    end

endmodule